// File: doc/BRIEF.md
# Dual-Issue Register Rename Unit

This block sits in the rename stage of an out-of-order core built around a reorder buffer (ROB). In every cycle it takes up to two instructions, each with two source register indices and one destination index. For each source it reports one of three cases. The value may still be in the architectural register file. The value may have been produced and now sit in a ROB entry. The value may still be pending, in which case the consumer must wait for a completion broadcast carrying a given ROB tag. Each instruction that writes a register gets a fresh ROB entry, and the alias table is pointed at that entry.

The alias table maps architectural registers straight to ROB tags; there is no separate physical register pool. A completion broadcast marks the matching mappings as produced, and this also takes effect in the same cycle for sources read while the broadcast is present. A commit from the ROB clears a mapping only when that mapping still names the committing tag. A flush discards every mapping and every in-flight allocation in one cycle. Dependences between the two instructions of one cycle are resolved inside the block. The ROB storage, the issue queues and the execution units lie outside the block and are represented only by their ports.

Top module: `rename_dual`

## Requirements
- R1: A source whose register has no live mapping reports map=0, pend=0 and tag 0. pend=1 only ever occurs together with map=1.
- R2: Register 0 is never renamed. As a source it always reports map=0 and pend=0. As a destination it takes no ROB entry and does not set dst_vld_o.
- R3: ROB tags are handed out in order from an allocation pointer that starts at 0 after reset and wraps modulo ROB_DEPTH. Slot 0 takes the first tag and slot 1 the next one. Only slots with valid=1, wen=1 and rd not 0 receive a tag, shown by dst_vld_o and dst_tag_o.
- R4: in_rdy_o is 0 when the free ROB entries are fewer than the destinations requested. In that case neither slot is renamed, no tag is taken and the table is left unchanged.
- R5: If a slot 1 source equals the register that slot 0 writes in the same cycle, that source reports map=1, pend=1 and slot 0's new tag.
- R6: If both slots write the same register in one cycle, later reads of that register return slot 1's tag.
- R7: A source whose register was renamed in an earlier cycle reports map=1 and the stored tag. It reports pend=1 until a completion for that tag has been seen.
- R8: A completion broadcast (cmp_vld_i, cmp_tag_i) makes every mapping that holds that tag read pend=0 while keeping map=1. This applies in the broadcast cycle itself and in all later cycles.
- R9: A commit port (ret_vld_i, ret_rd_i, ret_tag_i) unmaps ret_rd_i only when the table entry still holds ret_tag_i. A newer mapping of that register is left in place.
- R10: While flush_i is 1, in_rdy_o is 0. In the next cycle every register reads as unmapped, and the next tag handed out is the oldest tag that was in flight when the flush happened.
- R11: At most ROB_DEPTH tags are in flight. Each asserted commit port frees one entry from the following cycle on, so a commit does not free space in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard all mappings and in-flight allocations |
| in_vld_i | input | 2 | Instruction present, one bit per slot |
| in_rs1_i | input | 2x AW | First source register per slot |
| in_rs2_i | input | 2x AW | Second source register per slot |
| in_rd_i | input | 2x AW | Destination register per slot |
| in_wen_i | input | 2 | Slot writes its destination |
| in_rdy_o | output | 1 | Both slots renamed this cycle |
| src1_map_o | output | 2 | First source value lives in a ROB entry |
| src1_pend_o | output | 2 | First source must wait for broadcast |
| src1_tag_o | output | 2x TW | ROB tag of first source |
| src2_map_o | output | 2 | Second source value lives in a ROB entry |
| src2_pend_o | output | 2 | Second source must wait for broadcast |
| src2_tag_o | output | 2x TW | ROB tag of second source |
| dst_vld_o | output | 2 | Slot was given a ROB entry |
| dst_tag_o | output | 2x TW | ROB tag given to each slot |
| cmp_vld_i | input | 1 | Completion broadcast valid |
| cmp_tag_i | input | TW | Tag of the completed entry |
| ret_vld_i | input | 2 | Commit ports valid, oldest first |
| ret_rd_i | input | 2x AW | Destination register of each commit |
| ret_tag_i | input | 2x TW | ROB tag of each commit |

## Verification
Some rules hold in every cycle and are checked by assertions. Register 0 never reads as mapped. pend never appears without map. A slot 1 source that matches slot 0's destination takes slot 0's tag. A source read during a matching broadcast is not pending. The two tags given out in one cycle differ. A stall or a flush hands out no tag. The number of tags in flight, as counted from the port traffic, never goes above the ROB depth. Other behaviour spans several cycles and is shown by the bench's scenarios. These are: a second write to the same register winning over the first, a commit that finds a newer mapping and leaves it alone, the allocation pointer rewinding after a flush, and a commit whose freed space is only usable from the next cycle.

// File: rtl/rn_pkg.sv
package rn_pkg;

  // Resolution of one source operand
  typedef struct packed {
    logic map;   // value held in a ROB entry
    logic pend;  // value not produced yet
  } src_flags_t;

  function automatic logic [1:0] cnt2(input logic [1:0] v);
    return {1'b0, v[0]} + {1'b0, v[1]};
  endfunction

endpackage

// File: rtl/rn_rob_alloc.sv
module rn_rob_alloc #(
  parameter int ROB_DEPTH = 16,
  localparam int TW = $clog2(ROB_DEPTH),
  localparam int CW = $clog2(ROB_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_i,
  input  logic [1:0]          need_i,
  input  logic [1:0]          ret_vld_i,
  output logic                grant_o,
  output logic [1:0][TW-1:0]  tag_o
);
  import rn_pkg::*;

  logic [CW-1:0] count_q, count_d;
  logic [TW-1:0] tail_q, tail_d;
  logic [CW-1:0] free_w;
  logic [1:0]    need_n, alloc_n, ret_n;

  always_comb begin
    free_w  = CW'(ROB_DEPTH) - count_q;
    need_n  = cnt2(need_i);
    ret_n   = cnt2(ret_vld_i);
    grant_o = !flush_i && (free_w >= CW'(need_n));
    alloc_n = grant_o ? need_n : 2'd0;
    tag_o[0] = tail_q;
    tag_o[1] = tail_q + TW'(need_i[0]);
    if (flush_i) begin
      count_d = '0;
      tail_d  = tail_q - count_q[TW-1:0];  // rewind to oldest in flight
    end else begin
      count_d = count_q + CW'(alloc_n) - CW'(ret_n);
      tail_d  = tail_q + TW'(alloc_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      tail_q  <= '0;
    end else begin
      count_q <= count_d;
      tail_q  <= tail_d;
    end
  end

endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_REGS = 32,
  parameter int ROB_DEPTH = 16,
  parameter int RD_PORTS  = 4,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int TW = $clog2(ROB_DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush_i,
  input  logic [1:0]                 wr_en_i,
  input  logic [1:0][AW-1:0]         wr_rd_i,
  input  logic [1:0][TW-1:0]         wr_tag_i,
  input  logic                       cmp_vld_i,
  input  logic [TW-1:0]              cmp_tag_i,
  input  logic [1:0]                 ret_vld_i,
  input  logic [1:0][AW-1:0]         ret_rd_i,
  input  logic [1:0][TW-1:0]         ret_tag_i,
  input  logic [RD_PORTS-1:0][AW-1:0] rd_addr_i,
  output logic [RD_PORTS-1:0]        rd_map_o,
  output logic [RD_PORTS-1:0]        rd_done_o,
  output logic [RD_PORTS-1:0][TW-1:0] rd_tag_o
);

  logic          map_q  [ARCH_REGS];
  logic          map_d  [ARCH_REGS];
  logic          done_q [ARCH_REGS];
  logic          done_d [ARCH_REGS];
  logic [TW-1:0] tag_q  [ARCH_REGS];
  logic [TW-1:0] tag_d  [ARCH_REGS];
  logic          tag_en [ARCH_REGS];

  // Next state: commit clear, completion mark, then rename writes (slot 1 last), flush over all
  always_comb begin
    for (int r = 0; r < ARCH_REGS; r++) begin
      map_d[r]  = map_q[r];
      done_d[r] = done_q[r];
      tag_d[r]  = tag_q[r];
      tag_en[r] = 1'b0;
      if (cmp_vld_i && cmp_tag_i == tag_q[r]) done_d[r] = 1'b1;
      for (int k = 0; k < 2; k++) begin
        if (ret_vld_i[k] && ret_rd_i[k] == AW'(r) && ret_tag_i[k] == tag_q[r])
          map_d[r] = 1'b0;
      end
      for (int k = 0; k < 2; k++) begin
        if (wr_en_i[k] && wr_rd_i[k] == AW'(r)) begin
          map_d[r]  = 1'b1;
          done_d[r] = 1'b0;
          tag_d[r]  = wr_tag_i[k];
          tag_en[r] = 1'b1;
        end
      end
      if (flush_i || r == 0) begin
        map_d[r]  = 1'b0;
        done_d[r] = 1'b0;
      end
      if (r == 0) tag_en[r] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ARCH_REGS; r++) begin
        map_q[r]  <= 1'b0;
        done_q[r] <= 1'b0;
        tag_q[r]  <= '0;
      end
    end else begin
      for (int r = 0; r < ARCH_REGS; r++) begin
        map_q[r]  <= map_d[r];
        done_q[r] <= done_d[r];
        if (tag_en[r]) tag_q[r] <= tag_d[r];
      end
    end
  end

  // Read ports with same-cycle completion bypass
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [AW-1:0] a;
    assign a            = rd_addr_i[p];
    assign rd_map_o[p]  = map_q[a];
    assign rd_tag_o[p]  = map_q[a] ? tag_q[a] : '0;
    assign rd_done_o[p] = done_q[a] | (cmp_vld_i && cmp_tag_i == tag_q[a]);
  end

endmodule

// File: rtl/rn_src_resolve.sv
module rn_src_resolve #(
  parameter int ARCH_REGS = 32,
  parameter int ROB_DEPTH = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int TW = $clog2(ROB_DEPTH)
) (
  input  logic [AW-1:0]       rs_i,
  input  logic                fwd_en_i,
  input  logic [TW-1:0]       fwd_tag_i,
  input  logic                tbl_map_i,
  input  logic                tbl_done_i,
  input  logic [TW-1:0]       tbl_tag_i,
  output rn_pkg::src_flags_t  flags_o,
  output logic [TW-1:0]       tag_o
);

  always_comb begin
    flags_o = '0;
    tag_o   = '0;
    if (rs_i == '0) begin
      flags_o = '0;
    end else if (fwd_en_i) begin
      flags_o.map  = 1'b1;
      flags_o.pend = 1'b1;
      tag_o        = fwd_tag_i;
    end else if (tbl_map_i) begin
      flags_o.map  = 1'b1;
      flags_o.pend = !tbl_done_i;
      tag_o        = tbl_tag_i;
    end
  end

endmodule

// File: rtl/rename_dual.sv
module rename_dual #(
  parameter int ARCH_REGS = 32,
  parameter int ROB_DEPTH = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int TW = $clog2(ROB_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic [1:0]         in_vld_i,
  input  logic [1:0][AW-1:0] in_rs1_i,
  input  logic [1:0][AW-1:0] in_rs2_i,
  input  logic [1:0][AW-1:0] in_rd_i,
  input  logic [1:0]         in_wen_i,
  output logic               in_rdy_o,
  output logic [1:0]         src1_map_o,
  output logic [1:0]         src1_pend_o,
  output logic [1:0][TW-1:0] src1_tag_o,
  output logic [1:0]         src2_map_o,
  output logic [1:0]         src2_pend_o,
  output logic [1:0][TW-1:0] src2_tag_o,
  output logic [1:0]         dst_vld_o,
  output logic [1:0][TW-1:0] dst_tag_o,
  input  logic               cmp_vld_i,
  input  logic [TW-1:0]      cmp_tag_i,
  input  logic [1:0]         ret_vld_i,
  input  logic [1:0][AW-1:0] ret_rd_i,
  input  logic [1:0][TW-1:0] ret_tag_i
);
  import rn_pkg::*;

  localparam int NSRC = 4;  // two sources per slot

  logic [1:0]            need;
  logic                  grant;
  logic [1:0][TW-1:0]    alloc_tag;
  logic [1:0]            wr_en;
  logic [NSRC-1:0][AW-1:0] rd_addr;
  logic [NSRC-1:0]       rd_map, rd_done;
  logic [NSRC-1:0][TW-1:0] rd_tag;
  src_flags_t            flags [NSRC];
  logic [NSRC-1:0][TW-1:0] s_tag;

  for (genvar s = 0; s < 2; s++) begin : g_need
    assign need[s]  = in_vld_i[s] && in_wen_i[s] && (in_rd_i[s] != '0);
    assign wr_en[s] = grant && need[s];
    assign rd_addr[2*s]   = in_rs1_i[s];
    assign rd_addr[2*s+1] = in_rs2_i[s];
  end

  rn_rob_alloc #(.ROB_DEPTH(ROB_DEPTH)) i_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (flush_i),
    .need_i    (need),
    .ret_vld_i (ret_vld_i),
    .grant_o   (grant),
    .tag_o     (alloc_tag)
  );

  rn_map_table #(.ARCH_REGS(ARCH_REGS), .ROB_DEPTH(ROB_DEPTH), .RD_PORTS(NSRC)) i_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (flush_i),
    .wr_en_i   (wr_en),
    .wr_rd_i   (in_rd_i),
    .wr_tag_i  (alloc_tag),
    .cmp_vld_i (cmp_vld_i),
    .cmp_tag_i (cmp_tag_i),
    .ret_vld_i (ret_vld_i),
    .ret_rd_i  (ret_rd_i),
    .ret_tag_i (ret_tag_i),
    .rd_addr_i (rd_addr),
    .rd_map_o  (rd_map),
    .rd_done_o (rd_done),
    .rd_tag_o  (rd_tag)
  );

  // Slot 0 sources see only the table; slot 1 sources may forward from slot 0
  for (genvar p = 0; p < NSRC; p++) begin : g_src
    logic fwd;
    if (p < 2) begin : g_s0
      assign fwd = 1'b0;
    end else begin : g_s1
      assign fwd = need[0] && (in_rd_i[0] == rd_addr[p]);
    end
    rn_src_resolve #(.ARCH_REGS(ARCH_REGS), .ROB_DEPTH(ROB_DEPTH)) i_res (
      .rs_i       (rd_addr[p]),
      .fwd_en_i   (fwd),
      .fwd_tag_i  (alloc_tag[0]),
      .tbl_map_i  (rd_map[p]),
      .tbl_done_i (rd_done[p]),
      .tbl_tag_i  (rd_tag[p]),
      .flags_o    (flags[p]),
      .tag_o      (s_tag[p])
    );
  end

  for (genvar s = 0; s < 2; s++) begin : g_out
    assign src1_map_o[s]  = flags[2*s].map;
    assign src1_pend_o[s] = flags[2*s].pend;
    assign src1_tag_o[s]  = s_tag[2*s];
    assign src2_map_o[s]  = flags[2*s+1].map;
    assign src2_pend_o[s] = flags[2*s+1].pend;
    assign src2_tag_o[s]  = s_tag[2*s+1];
  end

  assign in_rdy_o  = grant;
  assign dst_vld_o = wr_en;
  assign dst_tag_o = alloc_tag;

endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int ARCH_REGS = 32,
  parameter int ROB_DEPTH = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int TW = $clog2(ROB_DEPTH),
  localparam int CW = $clog2(ROB_DEPTH + 1) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_i,
  input logic [1:0]         in_vld_i,
  input logic [1:0][AW-1:0] in_rs1_i,
  input logic [1:0][AW-1:0] in_rs2_i,
  input logic [1:0][AW-1:0] in_rd_i,
  input logic [1:0]         in_wen_i,
  input logic               in_rdy_o,
  input logic [1:0]         src1_map_o,
  input logic [1:0]         src1_pend_o,
  input logic [1:0][TW-1:0] src1_tag_o,
  input logic [1:0]         src2_map_o,
  input logic [1:0]         src2_pend_o,
  input logic [1:0][TW-1:0] src2_tag_o,
  input logic [1:0]         dst_vld_o,
  input logic [1:0][TW-1:0] dst_tag_o,
  input logic               cmp_vld_i,
  input logic [TW-1:0]      cmp_tag_i,
  input logic [1:0]         ret_vld_i,
  input logic [1:0][AW-1:0] ret_rd_i,
  input logic [1:0][TW-1:0] ret_tag_i
);

  // In-flight count rebuilt from port traffic only
  logic [CW-1:0] fly_q, fly_d;
  always_comb begin
    if (flush_i) fly_d = '0;
    else fly_d = fly_q + CW'(dst_vld_o[0]) + CW'(dst_vld_o[1])
                 - CW'(ret_vld_i[0]) - CW'(ret_vld_i[1]);
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fly_q <= '0;
    else        fly_q <= fly_d;
  end

  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fly_q <= CW'(ROB_DEPTH)); // R11

  for (genvar s = 0; s < 2; s++) begin : g_slot
    AST_X0_SRC1_READY: assert property (@(posedge clk) disable iff (!rst_n)
      in_rs1_i[s] == '0 |-> !src1_map_o[s] && !src1_pend_o[s]); // R2
    AST_X0_SRC2_READY: assert property (@(posedge clk) disable iff (!rst_n)
      in_rs2_i[s] == '0 |-> !src2_map_o[s] && !src2_pend_o[s]); // R2
    AST_PEND_NEEDS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (src1_pend_o[s] |-> src1_map_o[s]) and (src2_pend_o[s] |-> src2_map_o[s])); // R1
    AST_X0_NO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      in_rd_i[s] == '0 |-> !dst_vld_o[s]); // R2
  end

  AST_SAME_CYCLE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld_i[0] && in_wen_i[0] && in_rd_i[0] != '0 && in_rs1_i[1] == in_rd_i[0]
    |-> src1_map_o[1] && src1_pend_o[1] && src1_tag_o[1] == dst_tag_o[0]); // R5

  AST_DST_TAGS_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
    dst_vld_o == 2'b11 |-> dst_tag_o[0] != dst_tag_o[1]); // R3

  AST_STALL_NO_DST: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rdy_o |-> dst_vld_o == 2'b00); // R4

  AST_FLUSH_NO_DST: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> dst_vld_o == 2'b00); // R10

  AST_FLUSH_UNMAPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_i) |-> !src1_map_o[0] && !src2_map_o[0]); // R10

  AST_CMP_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld_i && src1_map_o[0] && src1_tag_o[0] == cmp_tag_i |-> !src1_pend_o[0]); // R8

endmodule

bind rename_dual rn_checker #(.ARCH_REGS(ARCH_REGS), .ROB_DEPTH(ROB_DEPTH)) i_rn_checker (.*);

// File: tb/test_rename_dual.sv
module test_rename_dual;
  localparam int NREG = 32, DEPTH = 16, AW = 5, TW = 4;

  logic clk, rst_n, flush;
  logic [1:0] vld, wen;
  logic [1:0][AW-1:0] rs1, rs2, rd;
  logic cmp_vld; logic [TW-1:0] cmp_tag;
  logic [1:0] ret_vld; logic [1:0][AW-1:0] ret_rd; logic [1:0][TW-1:0] ret_tag;
  logic rdy; logic [1:0] s1m, s1p, s2m, s2p, dv;
  logic [1:0][TW-1:0] s1t, s2t, dt;

  rename_dual i_rename_dual (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .in_vld_i(vld), .in_rs1_i(rs1),
    .in_rs2_i(rs2), .in_rd_i(rd), .in_wen_i(wen), .in_rdy_o(rdy),
    .src1_map_o(s1m), .src1_pend_o(s1p), .src1_tag_o(s1t),
    .src2_map_o(s2m), .src2_pend_o(s2p), .src2_tag_o(s2t),
    .dst_vld_o(dv), .dst_tag_o(dt), .cmp_vld_i(cmp_vld), .cmp_tag_i(cmp_tag),
    .ret_vld_i(ret_vld), .ret_rd_i(ret_rd), .ret_tag_i(ret_tag));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  int m_map[NREG], m_done[NREG], m_tag[NREG];
  int tail = 0, qh = 0, qn = 0;
  int q_tag[DEPTH], q_rd[DEPTH];
  int e_acc, e_need[2], e_tag[2];

  task automatic check(string req, int act, int exp, string what);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    vld = '0; wen = '0; rs1 = '0; rs2 = '0; rd = '0; flush = 1'b0;
    cmp_vld = 1'b0; cmp_tag = '0; ret_vld = '0; ret_rd = '0; ret_tag = '0;
  endtask

  task automatic slot(int s, int a, int b, int d, bit w);
    vld[s] = 1'b1; rs1[s] = AW'(a); rs2[s] = AW'(b); rd[s] = AW'(d); wen[s] = w;
  endtask

  task automatic retire(int n);
    for (int k = 0; k < n; k++) begin
      ret_vld[k] = 1'b1;
      ret_rd[k]  = AW'(q_rd[(qh + k) % DEPTH]);
      ret_tag[k] = TW'(q_tag[(qh + k) % DEPTH]);
    end
  endtask

  task automatic exp_src(int s, int r, output int m, output int p, output int t, output string rq);
    m = 0; p = 0; t = 0; rq = "R1";
    if (r == 0) rq = "R2";
    else if (s == 1 && e_need[0] == 1 && int'(rd[0]) == r) begin
      m = 1; p = 1; t = e_tag[0]; rq = "R5";
    end else if (m_map[r] == 1) begin
      bit hit = cmp_vld && int'(cmp_tag) == m_tag[r];
      m = 1; p = (m_done[r] == 1 || hit) ? 0 : 1; t = m_tag[r];
      rq = hit ? "R8" : "R7";
    end
  endtask

  task automatic settle();
    int m, p, t, r; string rq;
    #2;
    for (int s = 0; s < 2; s++) e_need[s] = (vld[s] && wen[s] && rd[s] != '0) ? 1 : 0;
    e_acc = (!flush && (DEPTH - qn) >= e_need[0] + e_need[1]) ? 1 : 0;
    e_tag[0] = tail; e_tag[1] = (tail + e_need[0]) % DEPTH;
    check("R4", int'(rdy), e_acc, "accept");
    for (int s = 0; s < 2; s++) begin
      check("R3", int'(dv[s]), e_acc & e_need[s], "dst valid");
      if (e_acc == 1 && e_need[s] == 1) check("R3", int'(dt[s]), e_tag[s], "dst tag");
      for (int k = 0; k < 2; k++) begin
        r = (k == 0) ? int'(rs1[s]) : int'(rs2[s]);
        exp_src(s, r, m, p, t, rq);
        check(rq, (k == 0) ? int'(s1m[s]) : int'(s2m[s]), m, "src map");
        check(rq, (k == 0) ? int'(s1p[s]) : int'(s2p[s]), p, "src pend");
        check(rq, (k == 0) ? int'(s1t[s]) : int'(s2t[s]), t, "src tag");
      end
    end
  endtask

  task automatic advance();
    if (flush) begin
      for (int r = 0; r < NREG; r++) m_map[r] = 0;
      tail = (tail - qn + DEPTH) % DEPTH; qn = 0;
    end else begin
      for (int k = 0; k < 2; k++) if (ret_vld[k]) begin
        int r = int'(ret_rd[k]);
        if (r != 0 && m_tag[r] == int'(ret_tag[k])) m_map[r] = 0;
        qh = (qh + 1) % DEPTH; qn--;
      end
      if (cmp_vld)
        for (int r = 0; r < NREG; r++)
          if (m_map[r] == 1 && m_tag[r] == int'(cmp_tag)) m_done[r] = 1;
      if (e_acc == 1)
        for (int s = 0; s < 2; s++) if (e_need[s] == 1) begin
          m_map[rd[s]] = 1; m_done[rd[s]] = 0; m_tag[rd[s]] = e_tag[s];
          q_tag[(qh + qn) % DEPTH] = e_tag[s]; q_rd[(qh + qn) % DEPTH] = int'(rd[s]);
          qn++; tail = (tail + 1) % DEPTH;
        end
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int old_head;
    void'($urandom(32'd20240611));
    for (int r = 0; r < NREG; r++) begin m_map[r] = 0; m_done[r] = 0; m_tag[r] = 0; end
    idle(); rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // Reset state: everything unmapped (R1)
    idle(); slot(0, 5, 7, 0, 0); slot(1, 9, 0, 0, 0);
    settle();
    check("R1", int'(s1m[0]), 0, "reset map");
    advance();

    // Same-cycle RAW and WAW on r3, x0 source (R5, R6, R2)
    idle(); slot(0, 1, 2, 3, 1); slot(1, 3, 0, 3, 1);
    settle();
    check("R5", int'(s1t[1]), 0, "fwd tag");
    check("R3", int'(dt[1]), 1, "second tag");
    advance();

    // Later read gets slot 1 tag; completion bypass in same cycle (R6, R8)
    idle(); slot(0, 3, 0, 0, 0); cmp_vld = 1'b1; cmp_tag = 4'd1;
    settle();
    check("R6", int'(s1t[0]), 1, "WAW survivor");
    check("R8", int'(s1p[0]), 0, "bypass pend");
    advance();

    // Commit of overwritten tag 0 leaves mapping (R9)
    idle(); retire(1); slot(0, 3, 0, 0, 0);
    settle(); advance();
    idle(); slot(0, 3, 0, 0, 0); retire(1);
    settle();
    check("R9", int'(s1m[0]), 1, "stale commit map");
    check("R9", int'(s1t[0]), 1, "stale commit tag");
    advance();
    idle(); slot(0, 3, 0, 0, 0);
    settle();
    check("R9", int'(s1m[0]), 0, "commit clears");
    advance();

    // Fill the ROB and stall (R4, R11)
    for (int i = 0; i < DEPTH / 2; i++) begin
      idle(); slot(0, 0, 0, 4, 1); slot(1, 4, 0, 5, 1);
      settle(); advance();
    end
    idle(); slot(0, 0, 0, 6, 1);
    settle();
    check("R11", int'(rdy), 0, "full stall");
    check("R4", int'(dv), 0, "no dst on stall");
    advance();
    idle(); slot(0, 0, 0, 6, 1); retire(1);
    settle();
    check("R11", int'(rdy), 0, "commit frees next cycle");
    advance();
    idle(); slot(0, 6, 0, 6, 1);
    settle();
    check("R11", int'(rdy), 1, "freed entry usable");
    check("R3", int'(dt[0]), 2, "wrapped tag");
    advance();

    // Flush (R10)
    old_head = q_tag[qh];
    idle(); slot(0, 4, 0, 6, 1); flush = 1'b1;
    settle();
    check("R10", int'(rdy), 0, "no accept on flush");
    advance();
    idle(); slot(0, 4, 5, 0, 0); slot(1, 6, 0, 7, 1);
    settle();
    check("R10", int'(s1m[0]), 0, "unmapped after flush");
    check("R10", int'(dt[1]), old_head, "tag rewinds");
    advance();

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      idle();
      flush = ($urandom % 64) == 0;
      for (int s = 0; s < 2; s++)
        if ($urandom % 4 != 0)
          slot(s, $urandom % 8, $urandom % 8, $urandom % 8, ($urandom % 3) != 0);
      if (!flush && qn > 0 && ($urandom % 2) == 1) retire((qn > 1 && ($urandom % 2) == 1) ? 2 : 1);
      if (qn > 0 && ($urandom % 2) == 1) begin
        cmp_vld = 1'b1;
        cmp_tag = TW'(q_tag[(qh + ($urandom % qn)) % DEPTH]);
      end
      settle(); advance();
    end
    finish_run();
  end

endmodule